// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Unit

This block applies memory-channel interleave swizzling to tiled-surface addresses and repairs page contents whose physical placement has moved between memory channels. On the address path, each incoming address has its bit 6 flipped by the XOR of a set of higher address bits. The set is picked by a 3-bit mode, and a separate mode is configured for X-tiled and for Y-tiled accesses. The result is registered, so it appears one clock after the request. How the memory is configured is decided outside the block; the two modes arrive as plain configuration inputs.

The second function is a page fix-up engine. A per-page record holds the physical address bit 17 that each page had when it was last saved. When a fix-up is requested for a page index together with the page's current bit 17, the engine compares the two values. On a mismatch it walks the 4 KiB page buffer through a 512-bit memory port, one 64-byte chunk per beat, and exchanges the two halves of every 128-byte group. It then signals completion and flags the page as dirty. On a match it completes at once and leaves the buffer untouched.

Top module: `swz6_unit`

## Requirements
- R1: The mode code selects the address bits XORed into bit 6: 0 none, 1 {9}, 2 {9,10}, 3 {9,11}, 4 {9,10,11}, 5 {9,17}, 6 {9,10,17}. `cfg_mode_y` applies when `ax_is_y` is 1, and `cfg_mode_x` applies otherwise.
- R2: `ax_out_vld` follows `ax_vld` with one clock of latency, and `ax_out_addr` differs from the request address in bit 6 at most.
- R3: Mode codes 0 and the reserved code 7 pass the address through unchanged.
- R4: A save command (`sav_vld`) writes `sav_b17` into the record entry at `sav_idx`. All record entries are 0 after reset.
- R5: A fix-up start whose `fix_b17` equals the recorded bit for `fix_idx` raises `fix_done` in the next cycle with `fix_dirty` 0 and makes no buffer write.
- R6: A fix-up start whose `fix_b17` differs from the record swaps buffer chunk 2g with chunk 2g+1 for every group g. `fix_done` rises 4*GROUPS+1 cycles after the start cycle (129 at defaults), with `fix_dirty` 1. `fix_done` lasts exactly one cycle.
- R7: A fix-up start presented while the engine is busy is ignored. It causes no further completion and no buffer access.
- R8: When a save and a fix-up start address the same page index in the same cycle, the comparison uses the record value from before the save, and the save still takes effect.
- R9: The buffer port uses chunk indices (byte offset / 64) on `buf_addr`. Read data returns on `buf_rdata` in the cycle after `buf_rd`. `buf_rd` and `buf_we` are never high together.
- R10: After reset, `ax_out_vld`, `fix_busy` and `fix_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ax_vld | input | 1 | Address request valid |
| ax_addr | input | ADDR_W | Address to swizzle |
| ax_is_y | input | 1 | 1 selects the Y-tiled mode, 0 the X-tiled mode |
| cfg_mode_x | input | 3 | Swizzle mode for X-tiled accesses |
| cfg_mode_y | input | 3 | Swizzle mode for Y-tiled accesses |
| ax_out_vld | output | 1 | Swizzled address valid |
| ax_out_addr | output | ADDR_W | Swizzled address |
| sav_vld | input | 1 | Save command: record a page's bit 17 |
| sav_idx | input | IDX_W | Page index for the save |
| sav_b17 | input | 1 | Current physical bit 17 to record |
| fix_start | input | 1 | Request a fix-up of the page buffer |
| fix_idx | input | IDX_W | Page index for the fix-up |
| fix_b17 | input | 1 | Current physical bit 17 of that page |
| fix_busy | output | 1 | Engine is running a fix-up |
| fix_done | output | 1 | One-cycle completion pulse |
| fix_dirty | output | 1 | Page was rewritten; valid with fix_done |
| buf_rd | output | 1 | Buffer read strobe |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | CHUNK_AW | Chunk index in the page |
| buf_wdata | output | DATA_W | Buffer write data |
| buf_rdata | input | DATA_W | Buffer read data, one cycle after buf_rd |

## Verification
A save command and a fix-up start can land in the same cycle on the same page index. The bench provokes this by driving both strobes on one clock for a page whose recorded bit is 0, with a current bit of 1. The outcome is judged at the ports: the completed fix-up must report dirty and show the buffer swapped, which shows that the old record was compared. A second fix-up of that page with the same bit must then complete at once without writes, which shows the save was kept. Address swizzling is also driven while a page walk is running, to confirm the two paths stay independent.

// File: rtl/swz6_pkg.sv
`timescale 1ns/1ps
package swz6_pkg;

    typedef enum logic [2:0] {
        SWZ_NONE     = 3'd0,
        SWZ_B9       = 3'd1,
        SWZ_B9_10    = 3'd2,
        SWZ_B9_11    = 3'd3,
        SWZ_B9_10_11 = 3'd4,
        SWZ_B9_17    = 3'd5,
        SWZ_B9_10_17 = 3'd6,
        SWZ_RSVD     = 3'd7
    } swz_mode_e;

    typedef enum logic [2:0] {
        FX_IDLE  = 3'd0,
        FX_RD_LO = 3'd1,
        FX_RD_HI = 3'd2,
        FX_WR_LO = 3'd3,
        FX_WR_HI = 3'd4,
        FX_DONE  = 3'd5
    } fx_state_e;

    // Fold of the mode-selected higher bits into one flip bit for bit 6.
    function automatic logic swz_flip(input logic [2:0] mode,
                                      input logic b9, input logic b10,
                                      input logic b11, input logic b17);
        logic f;
        case (swz_mode_e'(mode))
            SWZ_B9:       f = b9;
            SWZ_B9_10:    f = b9 ^ b10;
            SWZ_B9_11:    f = b9 ^ b11;
            SWZ_B9_10_11: f = b9 ^ b10 ^ b11;
            SWZ_B9_17:    f = b9 ^ b17;
            SWZ_B9_10_17: f = b9 ^ b10 ^ b17;
            default:      f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/swz6_addr_map.sv
`timescale 1ns/1ps
module swz6_addr_map
    import swz6_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_is_y,
    input  logic [2:0]        mode_x,
    input  logic [2:0]        mode_y,
    output logic              out_vld,
    output logic [ADDR_W-1:0] out_addr
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } am_st_t;

    am_st_t st_d, st_q;
    logic [2:0] sel_mode;
    logic       flip;

    always_comb begin
        sel_mode = in_is_y ? mode_y : mode_x;
        flip     = swz_flip(sel_mode, in_addr[9], in_addr[10], in_addr[11], in_addr[17]);
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.addr    = in_addr;
            st_d.addr[6] = in_addr[6] ^ flip;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_addr = st_q.addr;

endmodule

// File: rtl/swz6_b17_rec.sv
`timescale 1ns/1ps
module swz6_b17_rec #(
    parameter int PAGES = 16,
    localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sav_vld,
    input  logic [IDX_W-1:0] sav_idx,
    input  logic             sav_bit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    typedef struct packed {
        logic [PAGES-1:0] bits;
    } rec_st_t;

    rec_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sav_vld && (32'(sav_idx) < PAGES))
            st_d.bits[sav_idx] = sav_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read the registered value: a save in this cycle is not yet visible.
    assign rd_bit = (32'(rd_idx) < PAGES) ? st_q.bits[rd_idx] : 1'b0;

endmodule

// File: rtl/swz6_page_fix.sv
`timescale 1ns/1ps
module swz6_page_fix
    import swz6_pkg::*;
#(
    parameter int DATA_W     = 512,
    parameter int PAGE_BYTES = 4096,
    localparam int CHUNKS    = PAGE_BYTES / (DATA_W / 8),
    localparam int GROUPS    = CHUNKS / 2,
    localparam int CHUNK_AW  = $clog2(CHUNKS),
    localparam int GRP_W     = CHUNK_AW - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cur_b17,
    input  logic                rec_b17,
    output logic                busy,
    output logic                done,
    output logic                dirty,
    output logic                mem_rd,
    output logic                mem_we,
    output logic [CHUNK_AW-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata
);

    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(GROUPS - 1);

    typedef struct packed {
        fx_state_e         state;
        logic [GRP_W-1:0]  grp;
        logic [DATA_W-1:0] lo_data;
        logic              dirty;
    } fx_st_t;

    fx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            FX_IDLE: begin
                if (start) begin
                    st_d.grp   = '0;
                    st_d.dirty = cur_b17 ^ rec_b17;
                    st_d.state = (cur_b17 ^ rec_b17) ? FX_RD_LO : FX_DONE;
                end
            end
            FX_RD_LO: st_d.state = FX_RD_HI;
            FX_RD_HI: begin
                // Low chunk returns now (read issued last beat).
                st_d.lo_data = mem_rdata;
                st_d.state   = FX_WR_LO;
            end
            FX_WR_LO: st_d.state = FX_WR_HI;
            FX_WR_HI: begin
                if (st_q.grp == LAST_GRP) begin
                    st_d.state = FX_DONE;
                end else begin
                    st_d.grp   = st_q.grp + 1'b1;
                    st_d.state = FX_RD_LO;
                end
            end
            FX_DONE:  st_d.state = FX_IDLE;
            default:  st_d.state = FX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: FX_IDLE, grp: '0, lo_data: '0, dirty: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        mem_rd    = (st_q.state == FX_RD_LO) || (st_q.state == FX_RD_HI);
        mem_we    = (st_q.state == FX_WR_LO) || (st_q.state == FX_WR_HI);
        mem_addr  = {st_q.grp, (st_q.state == FX_RD_HI) || (st_q.state == FX_WR_HI)};
        // High chunk arrives during WR_LO and goes straight to the low slot.
        mem_wdata = (st_q.state == FX_WR_LO) ? mem_rdata : st_q.lo_data;
    end

    assign busy  = (st_q.state != FX_IDLE);
    assign done  = (st_q.state == FX_DONE);
    assign dirty = st_q.dirty;

endmodule

// File: rtl/swz6_unit.sv
`timescale 1ns/1ps
module swz6_unit #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 512,
    parameter int PAGE_BYTES = 4096,
    parameter int PAGES      = 16,
    localparam int IDX_W     = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int CHUNK_AW  = $clog2(PAGE_BYTES / (DATA_W / 8))
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ax_vld,
    input  logic [ADDR_W-1:0]   ax_addr,
    input  logic                ax_is_y,
    input  logic [2:0]          cfg_mode_x,
    input  logic [2:0]          cfg_mode_y,
    output logic                ax_out_vld,
    output logic [ADDR_W-1:0]   ax_out_addr,
    input  logic                sav_vld,
    input  logic [IDX_W-1:0]    sav_idx,
    input  logic                sav_b17,
    input  logic                fix_start,
    input  logic [IDX_W-1:0]    fix_idx,
    input  logic                fix_b17,
    output logic                fix_busy,
    output logic                fix_done,
    output logic                fix_dirty,
    output logic                buf_rd,
    output logic                buf_we,
    output logic [CHUNK_AW-1:0] buf_addr,
    output logic [DATA_W-1:0]   buf_wdata,
    input  logic [DATA_W-1:0]   buf_rdata
);

    logic rec_bit;

    swz6_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (ax_vld),
        .in_addr  (ax_addr),
        .in_is_y  (ax_is_y),
        .mode_x   (cfg_mode_x),
        .mode_y   (cfg_mode_y),
        .out_vld  (ax_out_vld),
        .out_addr (ax_out_addr)
    );

    swz6_b17_rec #(.PAGES(PAGES)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .sav_vld (sav_vld),
        .sav_idx (sav_idx),
        .sav_bit (sav_b17),
        .rd_idx  (fix_idx),
        .rd_bit  (rec_bit)
    );

    swz6_page_fix #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_fix (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fix_start),
        .cur_b17   (fix_b17),
        .rec_b17   (rec_bit),
        .busy      (fix_busy),
        .done      (fix_done),
        .dirty     (fix_dirty),
        .mem_rd    (buf_rd),
        .mem_we    (buf_we),
        .mem_addr  (buf_addr),
        .mem_wdata (buf_wdata),
        .mem_rdata (buf_rdata)
    );

endmodule

// File: rtl/swz6_unit_chk.sv
`timescale 1ns/1ps
module swz6_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ax_vld,
    input logic [ADDR_W-1:0] ax_addr,
    input logic              ax_is_y,
    input logic [2:0]        cfg_mode_x,
    input logic [2:0]        cfg_mode_y,
    input logic              ax_out_vld,
    input logic [ADDR_W-1:0] ax_out_addr,
    input logic              fix_busy,
    input logic              fix_done,
    input logic              buf_rd,
    input logic              buf_we
);

    localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << 6);

    logic [2:0] cur_mode;
    assign cur_mode = ax_is_y ? cfg_mode_y : cfg_mode_x;

    // R2
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ax_out_vld |-> (((ax_out_addr ^ $past(ax_addr)) & KEEP_MASK) == '0));

    // R2
    vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ax_vld |=> ax_out_vld);

    // R3
    none_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_vld && (cur_mode == 3'd0 || cur_mode == 3'd7)) |=> (ax_out_addr == $past(ax_addr)));

    // R9
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd && buf_we));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_done |=> !fix_done);

    // R7
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_busy && !fix_done) |=> fix_busy);

    // R5
    we_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (fix_busy && !fix_done));

endmodule

bind swz6_unit swz6_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ax_vld      (ax_vld),
    .ax_addr     (ax_addr),
    .ax_is_y     (ax_is_y),
    .cfg_mode_x  (cfg_mode_x),
    .cfg_mode_y  (cfg_mode_y),
    .ax_out_vld  (ax_out_vld),
    .ax_out_addr (ax_out_addr),
    .fix_busy    (fix_busy),
    .fix_done    (fix_done),
    .buf_rd      (buf_rd),
    .buf_we      (buf_we)
);

// File: tb/swz6_unit_test.sv
`timescale 1ns/1ps
module swz6_unit_test;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 512;
    localparam int PAGES  = 16;
    localparam int IDX_W  = 4;
    localparam int NCH    = 64;
    localparam int CAW    = 6;
    localparam int WALK_N = 4 * (NCH / 2) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ax_vld = 1'b0;
    logic [ADDR_W-1:0] ax_addr = '0;
    logic              ax_is_y = 1'b0;
    logic [2:0]        cfg_mode_x = '0;
    logic [2:0]        cfg_mode_y = '0;
    logic              ax_out_vld;
    logic [ADDR_W-1:0] ax_out_addr;
    logic              sav_vld = 1'b0;
    logic [IDX_W-1:0]  sav_idx = '0;
    logic              sav_b17 = 1'b0;
    logic              fix_start = 1'b0;
    logic [IDX_W-1:0]  fix_idx = '0;
    logic              fix_b17 = 1'b0;
    logic              fix_busy, fix_done, fix_dirty;
    logic              buf_rd, buf_we;
    logic [CAW-1:0]    buf_addr;
    logic [DATA_W-1:0] buf_wdata;
    logic [DATA_W-1:0] buf_rdata;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    swz6_unit uut (.*);

    // Buffer model: one-cycle read latency, write count kept for checks.
    logic [DATA_W-1:0] bmem [NCH];
    logic [DATA_W-1:0] bref [NCH];
    logic              preload = 1'b0;
    int                wr_cnt = 0;
    int                acc_cnt = 0;

    function automatic logic [DATA_W-1:0] pat(input int k);
        logic [31:0] w;
        w = 32'(k) * 32'h9E3779B1 + 32'h1234_5678;
        return {16{w}};
    endfunction

    always @(posedge clk) begin
        if (preload) begin
            for (int k = 0; k < NCH; k++) bmem[k] <= pat(k);
        end else begin
            if (buf_rd) buf_rdata <= bmem[buf_addr];
            if (buf_we) begin
                bmem[buf_addr] <= buf_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (buf_rd || buf_we) acc_cnt <= acc_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    // Independent model of the swizzle: mask of {b17,b11,b10,b9} per mode.
    function automatic logic [ADDR_W-1:0] exp_swz(input logic [ADDR_W-1:0] a, input logic [2:0] m);
        logic [3:0] msk;
        logic [ADDR_W-1:0] r;
        case (m)
            3'd1: msk = 4'b0001;
            3'd2: msk = 4'b0011;
            3'd3: msk = 4'b0101;
            3'd4: msk = 4'b0111;
            3'd5: msk = 4'b1001;
            3'd6: msk = 4'b1011;
            default: msk = 4'b0000;
        endcase
        r = a;
        r[6] = a[6] ^ (^(msk & {a[17], a[11], a[10], a[9]}));
        return r;
    endfunction

    task automatic swap_ref();
        for (int g = 0; g < NCH / 2; g++) begin
            logic [DATA_W-1:0] t;
            t = bref[2*g];
            bref[2*g] = bref[2*g+1];
            bref[2*g+1] = t;
        end
    endtask

    task automatic cmp_mem(input string tag);
        int miss = 0;
        for (int k = 0; k < NCH; k++) if (bmem[k] !== bref[k]) miss++;
        check(miss == 0, tag, 64'(miss), 64'd0);
    endtask

    // Start a fix-up and count negedges until done (0 if none seen).
    task automatic run_fix(input logic [IDX_W-1:0] idx, input logic b17, output int n);
        @(negedge clk);
        fix_start = 1'b1; fix_idx = idx; fix_b17 = b17;
        n = 0;
        for (int c = 1; c <= 300; c++) begin
            @(negedge clk);
            fix_start = 1'b0;
            if (fix_done) begin n = c; break; end
        end
    endtask

    task automatic t_reset();
        check(ax_out_vld == 1'b0, "R10 out_vld", 64'(ax_out_vld), 0);
        check(fix_busy == 1'b0,   "R10 busy",    64'(fix_busy), 0);
        check(fix_done == 1'b0,   "R10 done",    64'(fix_done), 0);
    endtask

    task automatic t_addr();
        logic [ADDR_W-1:0] av [3];
        av[0] = 32'h0002_0E40; av[1] = 32'h0000_0A00; av[2] = 32'hFFFD_F5BF;
        for (int m = 0; m < 8; m++) begin
            for (int y = 0; y < 2; y++) begin
                for (int i = 0; i < 3; i++) begin
                    logic [ADDR_W-1:0] e;
                    @(negedge clk);
                    ax_vld = 1'b1; ax_addr = av[i]; ax_is_y = y[0];
                    // Other tiling kind gets a different mode to prove selection.
                    if (y == 1) begin cfg_mode_y = 3'(m); cfg_mode_x = 3'(6 - (m % 7)); end
                    else        begin cfg_mode_x = 3'(m); cfg_mode_y = 3'(6 - (m % 7)); end
                    e = exp_swz(av[i], 3'(m));
                    @(negedge clk);
                    ax_vld = 1'b0;
                    check(ax_out_vld == 1'b1, "R2 out_vld", 64'(ax_out_vld), 1);
                    if (m == 0 || m == 7)
                        check(ax_out_addr == av[i], "R3 passthrough", 64'(ax_out_addr), 64'(av[i]));
                    else
                        check(ax_out_addr == e, "R1 swizzle", 64'(ax_out_addr), 64'(e));
                end
            end
        end
        @(negedge clk);
        check(ax_out_vld == 1'b0, "R2 out_vld drop", 64'(ax_out_vld), 0);
    endtask

    task automatic t_match_reset_rec();
        int n, w0;
        w0 = wr_cnt;
        run_fix(4'd5, 1'b0, n);
        check(n == 1, "R5 done latency", 64'(n), 1);
        check(fix_dirty == 1'b0, "R5 dirty", 64'(fix_dirty), 0);
        check(wr_cnt == w0, "R5 no write", 64'(wr_cnt - w0), 0);
        cmp_mem("R5 buffer intact");
    endtask

    task automatic t_save_swap();
        int n, w0;
        @(negedge clk);
        sav_vld = 1'b1; sav_idx = 4'd2; sav_b17 = 1'b1;
        @(negedge clk);
        sav_vld = 1'b0;
        w0 = wr_cnt;
        run_fix(4'd2, 1'b0, n);
        swap_ref();
        check(n == WALK_N, "R6 done latency", 64'(n), 64'(WALK_N));
        check(fix_dirty == 1'b1, "R6 dirty", 64'(fix_dirty), 1);
        check(wr_cnt - w0 == NCH, "R9 write beats", 64'(wr_cnt - w0), 64'(NCH));
        cmp_mem("R6 pair swap");
        @(negedge clk);
        check(fix_done == 1'b0, "R6 done pulse", 64'(fix_done), 0);
        w0 = wr_cnt;
        run_fix(4'd2, 1'b1, n);
        check(n == 1 && fix_dirty == 1'b0, "R4 saved bit matches", 64'(n), 1);
        check(wr_cnt == w0, "R4 no write", 64'(wr_cnt - w0), 0);
    endtask

    task automatic t_busy_ignore();
        int a0, n, extra;
        a0 = acc_cnt;
        @(negedge clk);
        fix_start = 1'b1; fix_idx = 4'd4; fix_b17 = 1'b1;
        n = 0;
        for (int c = 1; c <= 300; c++) begin
            @(negedge clk);
            fix_start = 1'b0;
            if (c == 10) begin fix_start = 1'b1; fix_idx = 4'd5; fix_b17 = 1'b1; end
            // Address path runs alongside the walk.
            if (c == 20) begin ax_vld = 1'b1; ax_addr = 32'h0000_0200; ax_is_y = 1'b0; cfg_mode_x = 3'd1; end
            if (c == 21) begin
                ax_vld = 1'b0;
                check(ax_out_addr == 32'h0000_0240, "R1 during walk", 64'(ax_out_addr), 64'h240);
            end
            if (fix_done) begin n = c; break; end
        end
        swap_ref();
        check(n == WALK_N, "R7 first walk", 64'(n), 64'(WALK_N));
        extra = 0;
        for (int c = 0; c < 140; c++) begin
            @(negedge clk);
            if (fix_done) extra++;
        end
        check(extra == 0, "R7 no second done", 64'(extra), 0);
        check(acc_cnt - a0 == 2 * NCH, "R7 access count", 64'(acc_cnt - a0), 64'(2 * NCH));
        cmp_mem("R7 single swap");
    endtask

    task automatic t_same_cycle();
        int n, w0;
        @(negedge clk);
        sav_vld = 1'b1; sav_idx = 4'd3; sav_b17 = 1'b1;
        fix_start = 1'b1; fix_idx = 4'd3; fix_b17 = 1'b1;
        n = 0;
        for (int c = 1; c <= 300; c++) begin
            @(negedge clk);
            sav_vld = 1'b0; fix_start = 1'b0;
            if (fix_done) begin n = c; break; end
        end
        swap_ref();
        check(n == WALK_N && fix_dirty == 1'b1, "R8 old record compared", 64'(n), 64'(WALK_N));
        cmp_mem("R8 swap");
        w0 = wr_cnt;
        run_fix(4'd3, 1'b1, n);
        check(n == 1 && fix_dirty == 1'b0, "R8 save kept", 64'(n), 1);
        check(wr_cnt == w0, "R8 no write", 64'(wr_cnt - w0), 0);
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) bref[k] = pat(k);
        preload = 1'b1;
        repeat (3) @(negedge clk);
        preload = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_match_reset_rec();
        t_save_swap();
        t_busy_ignore();
        t_same_cycle();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=0x1 exp=0x0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule